// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, horizontal blank, vertical blank and active-video strobes of a progressive raster. A pixel counter and a line counter step once per clock while the generator is enabled. Every output is derived from their position and a set of timing values that software loads through a plain write-strobe register port.

All timing values are 13 bits wide and are packed two to a 32-bit word. Writes land in shadow copies. The timing set that drives the counters takes those copies only after software commits them, and the hand-over happens at a frame boundary, so a frame never mixes two timing sets.

The position at which vertical blank and vertical sync toggle inside a line can be programmed. Each output has its own polarity. Two sticky flags record vertical-blank entry and the start of active video, and each flag can raise the interrupt line.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every shadow and working timing field is 0, all polarity bits are 1 (active high), the generator is disabled, the status and interrupt-enable bits are 0, all five timing outputs are low and `irq_o` is low.
- R2: The write/read map is addressed by word index:
  - 0 control: bit 2 enable, bit 1 commit.
  - 1 status: bit 12 vblank, bit 13 active.
  - 2 interrupt enable: same bit positions as status.
  - 3 polarity: bit 0 vblank, bit 1 hblank, bit 2 vsync, bit 3 hsync, bit 4 active.
  - 4 active size: lines in 28:16, pixels in 12:0.
  - 5 line length in 12:0.
  - 6 frame height in 12:0.
  - 7 hsync: end in 28:16, start in 12:0.
  - 8 vsync lines: end in 28:16, start in 12:0.
  - 9 vblank pixel offsets: end in 28:16, start in 12:0.
  - 10 vsync pixel offsets: end in 28:16, start in 12:0.
  
  Reads return the shadow values. A control read shows the enable in bit 2 and a pending commit in bit 1.
- R3: While enabled, the pixel counter runs from 0 to line length minus 1 and then wraps to 0, advancing the line counter. The line counter wraps to 0 after frame height minus 1.
- R4: Horizontal blank is asserted while pixel >= active pixels. Active video is asserted while pixel < active pixels and line < active lines.
- R5: Horizontal sync is asserted while hsync start <= pixel < hsync end.
- R6: Vertical blank is asserted from (line = active lines, pixel = vblank start offset) up to (line 0, pixel = vblank end offset). Vertical sync is asserted from (vsync start line, vsync start offset) up to (vsync end line, vsync end offset). With zero offsets both toggle at pixel 0.
- R7: A polarity bit of 1 drives the output high when asserted. A bit of 0 inverts it, so an idle output sits high.
- R8: Shadow writes do not affect the outputs. Writing 1 to control bit 1 marks a commit. While running, a commit loads the working set on the clock edge at which the counters return to pixel 0 of line 0. While disabled, it loads on the next edge.
- R9: Writing control with bit 2 clear disables generation. The raw strobes go inactive at once and the counters return to 0. The first enabled cycle shows pixel 0 of line 0.
- R10: Status bit 12 sets one cycle after vertical blank begins, and bit 13 sets one cycle after active video begins. Both bits are sticky and are cleared by writing 1. Writing 0 leaves them unchanged, and a new set wins over a clear in the same cycle.
- R11: `irq_o` is high exactly when some status bit and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word index |
| rd_data | output | 32 | Read data (combinational) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| active_o | output | 1 | Active video |
| irq_o | output | 1 | Interrupt |

## Verification
The bound checker watches several rules on every cycle:
- the counters sit at the origin after a disabled cycle;
- the pixel counter stays below the line length;
- the working timing set changes only at the frame origin;
- active video never overlaps horizontal blank;
- a status flag rises only after its raw strobe;
- the interrupt line stays low when no source is enabled.

Only the bench scenarios can show the exact raster shapes for each timing set, polarity and edge offset. The same applies to a shadow write with no commit having no effect, and to the clear-by-one and write-zero behaviour of the status flags.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int TW = 13,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          active_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_CTRL = 0, A_STAT = 1, A_IEN = 2, A_POL = 3,
                            A_ACT = 4, A_HTOT = 5, A_VTOT = 6, A_HS = 7,
                            A_VS = 8, A_VBOF = 9, A_VSOF = 10;
  localparam logic [TW:0]   ONE_W = 1;
  localparam logic [TW-1:0] ONE_T = 1;

  typedef struct packed {
    logic [TW-1:0] hact, vact, htot, vtot;
    logic [TW-1:0] hss, hse, vss, vse;
    logic [TW-1:0] vbs, vbe, vos, voe;
    logic [4:0]    pol;
  } tcfg_t;

  tcfg_t sh, wk;
  logic en, pend, load;
  logic [1:0] stat, ien, clr, setb;
  logic [TW-1:0] h, v;
  logic h_last, v_last;
  logic hs_raw, vs_raw, hb_raw, vb_raw, act_raw;
  logic vb_q, act_q;
  logic [TW-1:0] htot_w;
  logic unused_wr;

  function automatic logic past_pt(input logic [TW-1:0] lv, lh, pl, pp);
    return (lv > pl) || (lv == pl && lh >= pp);
  endfunction

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;

  assign unused_wr = ^wr_data;
  assign htot_w = wk.htot;
  assign h_last = ({1'b0, h} + ONE_W) >= {1'b0, wk.htot};
  assign v_last = ({1'b0, v} + ONE_W) >= {1'b0, wk.vtot};
  assign load   = pend && (!en || (h_last && v_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      sh.pol <= '1;
      en <= 1'b0;
      pend <= 1'b0;
      ien <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: en <= wr_data[2];
        A_IEN:  ien <= wr_data[13:12];
        A_POL:  sh.pol <= wr_data[4:0];
        A_ACT:  begin sh.hact <= wr_data[TW-1:0]; sh.vact <= wr_data[16 +: TW]; end
        A_HTOT: sh.htot <= wr_data[TW-1:0];
        A_VTOT: sh.vtot <= wr_data[TW-1:0];
        A_HS:   begin sh.hss <= wr_data[TW-1:0]; sh.hse <= wr_data[16 +: TW]; end
        A_VS:   begin sh.vss <= wr_data[TW-1:0]; sh.vse <= wr_data[16 +: TW]; end
        A_VBOF: begin sh.vbs <= wr_data[TW-1:0]; sh.vbe <= wr_data[16 +: TW]; end
        A_VSOF: begin sh.vos <= wr_data[TW-1:0]; sh.voe <= wr_data[16 +: TW]; end
        default: ;
      endcase
    end
    if (rst_n)
      pend <= (pend && !load) || (wr_ctrl && wr_data[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wk <= '0;
      wk.pol <= '1;
    end else if (load) begin
      wk <= sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      h <= '0;
      v <= '0;
    end else if (h_last) begin
      h <= '0;
      v <= v_last ? '0 : v + ONE_T;
    end else begin
      h <= h + ONE_T;
    end
  end

  assign hb_raw  = en && (h >= wk.hact);
  assign act_raw = en && (h < wk.hact) && (v < wk.vact);
  assign hs_raw  = en && (h >= wk.hss) && (h < wk.hse);
  assign vb_raw  = en && (past_pt(v, h, wk.vact, wk.vbs) || (v == '0 && h < wk.vbe));
  assign vs_raw  = en && past_pt(v, h, wk.vss, wk.vos) && !past_pt(v, h, wk.vse, wk.voe);

  assign vblank_o = ~(vb_raw  ^ wk.pol[0]);
  assign hblank_o = ~(hb_raw  ^ wk.pol[1]);
  assign vsync_o  = ~(vs_raw  ^ wk.pol[2]);
  assign hsync_o  = ~(hs_raw  ^ wk.pol[3]);
  assign active_o = ~(act_raw ^ wk.pol[4]);

  assign clr  = (wr_en && wr_addr == A_STAT) ? wr_data[13:12] : 2'b00;
  assign setb = {act_raw && !act_q, vb_raw && !vb_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat  <= '0;
      vb_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      stat  <= (stat & ~clr) | setb;
      vb_q  <= vb_raw;
      act_q <= act_raw;
    end
  end

  assign irq_o = |(stat & ien);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {29'b0, en, pend, 1'b0};
      A_STAT:  rd_data = {18'b0, stat, 12'b0};
      A_IEN:   rd_data = {18'b0, ien, 12'b0};
      A_POL:   rd_data = {27'b0, sh.pol};
      A_ACT:   rd_data = (32'(sh.vact) << 16) | 32'(sh.hact);
      A_HTOT:  rd_data = 32'(sh.htot);
      A_VTOT:  rd_data = 32'(sh.vtot);
      A_HS:    rd_data = (32'(sh.hse) << 16) | 32'(sh.hss);
      A_VS:    rd_data = (32'(sh.vse) << 16) | 32'(sh.vss);
      A_VBOF:  rd_data = (32'(sh.vbe) << 16) | 32'(sh.vbs);
      A_VSOF:  rd_data = (32'(sh.voe) << 16) | 32'(sh.vos);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int TW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [TW-1:0] h,
  input logic [TW-1:0] v,
  input logic [TW-1:0] htot_w,
  input logic          vb_raw,
  input logic          act_raw,
  input logic          hb_raw,
  input logic [1:0]    stat,
  input logic [1:0]    ien,
  input logic          irq_o
);

  assert_idle_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (h == '0 && v == '0));

  assert_pixel_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (htot_w != '0) |-> (h < htot_w));

  assert_commit_at_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(htot_w) |-> (h == '0 && v == '0));

  assert_active_not_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_raw |-> !hb_raw);

  assert_vb_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(vb_raw));

  assert_act_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(act_raw));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq_o);

endmodule

bind raster_timing_gen raster_timing_gen_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .h(h), .v(v), .htot_w(htot_w),
  .vb_raw(vb_raw), .act_raw(act_raw), .hb_raw(hb_raw),
  .stat(stat), .ien(ien), .irq_o(irq_o)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

  localparam int A_CTRL = 0, A_STAT = 1, A_IEN = 2, A_POL = 3, A_ACT = 4,
                 A_HTOT = 5, A_VTOT = 6, A_HS = 7, A_VS = 8, A_VBOF = 9, A_VSOF = 10;
  // htot vtot hact vact hss hse vss vse vbs vbe vos voe pol
  localparam int CFG [4][13] = '{
    '{12, 8,  8, 5, 9, 11, 6, 7, 0, 0, 0, 0, 31},
    '{10, 6,  6, 4, 7,  9, 4, 5, 3, 5, 2, 8,  6},
    '{16, 5, 16, 5, 0,  0, 1, 3, 0, 0, 0, 0,  0},
    '{ 7, 4,  3, 1, 3,  7, 0, 1, 0, 0, 6, 0, 31}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic hsync_o, vsync_o, hblank_o, vblank_o, active_o, irq_o;
  int n_chk = 0, n_bad = 0;
  int cur[13], nxt[13];
  int bh = 0, bv = 0;
  bit pend_b = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .active_o(active_o), .irq_o(irq_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (pos %0d,%0d)", tag, act, exp, bh, bv);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_addr = 4'(a);
    #1 d = rd_data;
  endtask

  function automatic bit after_pt(int l, int p);
    return (bv > l) || (bv == l && bh >= p);
  endfunction

  function automatic logic [4:0] model();
    bit hb, act, hs, vb, vs;
    hb  = bh >= cur[2];
    act = bh < cur[2] && bv < cur[3];
    hs  = bh >= cur[4] && bh < cur[5];
    vb  = after_pt(cur[3], cur[8]) || (bv == 0 && bh < cur[9]);
    vs  = after_pt(cur[6], cur[10]) && !after_pt(cur[7], cur[11]);
    return {act ~^ cur[12][4], vb ~^ cur[12][0], hb ~^ cur[12][1],
            vs ~^ cur[12][2], hs ~^ cur[12][3]};
  endfunction

  task automatic step_b();
    bh++;
    if (bh >= cur[0]) begin
      bh = 0; bv++;
      if (bv >= cur[1]) begin
        bv = 0;
        if (pend_b) begin cur = nxt; pend_b = 0; end
      end
    end
  endtask

  task automatic run_px(int n);
    for (int i = 0; i < n; i++) begin
      chk("R3/R4/R5/R6/R7 raster", {27'b0, active_o, vblank_o, hblank_o, vsync_o, hsync_o},
          {27'b0, model()});
      @(negedge clk);
      step_b();
    end
  endtask

  task automatic wr_run(int a, int d, bit upd);
    wr(a, d);
    step_b();
    if (upd) pend_b = 1;
  endtask

  task automatic load_cfg(int r);
    wr(A_CTRL, 0);
    wr(A_HTOT, CFG[r][0]);
    wr(A_VTOT, CFG[r][1]);
    wr(A_ACT, (CFG[r][3] << 16) | CFG[r][2]);
    wr(A_HS, (CFG[r][5] << 16) | CFG[r][4]);
    wr(A_VS, (CFG[r][7] << 16) | CFG[r][6]);
    wr(A_VBOF, (CFG[r][9] << 16) | CFG[r][8]);
    wr(A_VSOF, (CFG[r][11] << 16) | CFG[r][10]);
    wr(A_POL, CFG[r][12]);
    wr(A_CTRL, 2);
    wr(A_CTRL, 4);
    for (int k = 0; k < 13; k++) cur[k] = CFG[r][k];
    bh = 0; bv = 0; pend_b = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 outputs", {27'b0, active_o, vblank_o, hblank_o, vsync_o, hsync_o}, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_POL, d);  chk("R1 polarity", d, 32'h1F);
    rd(A_HTOT, d); chk("R1 line length", d, 0);

    // table walk: R3..R7 raster shapes, R9 start at origin
    for (int r = 0; r < 4; r++) begin
      load_cfg(r);
      run_px(2 * CFG[r][0] * CFG[r][1] + 3);
      if (r == 1) begin
        rd(A_ACT, d);  chk("R2 active size readback", d, (4 << 16) | 6);
        rd(A_VSOF, d); chk("R2 vsync offset readback", d, (8 << 16) | 2);
      end
    end

    // R8: shadow write without commit has no effect, commit takes effect at frame start
    load_cfg(0);
    run_px(40);
    wr_run(A_ACT, (5 << 16) | 4, 0);
    rd(A_CTRL, d); chk("R2 R8 no commit pending", d, 4);
    run_px(2 * 96);
    nxt = cur; nxt[2] = 4;
    wr_run(A_CTRL, 6, 1);
    rd(A_CTRL, d); chk("R8 commit pending", d, 6);
    run_px(2 * 96 + 5);
    rd(A_CTRL, d); chk("R8 commit consumed", d, 4);
    chk("R8 model switched", cur[2], 4);

    // R9: disable makes outputs inactive
    wr(A_CTRL, 0);
    chk("R9 idle outputs", {27'b0, active_o, vblank_o, hblank_o, vsync_o, hsync_o}, 0);
    repeat (7) @(negedge clk);
    chk("R9 idle outputs later", {27'b0, active_o, vblank_o, hblank_o, vsync_o, hsync_o}, 0);

    // R10 / R11: sticky status, clear by one, interrupt masking
    rd(A_STAT, d); chk("R10 flags set", d, 32'h3000);
    chk("R11 irq masked", {31'b0, irq_o}, 0);
    wr(A_IEN, 1 << 12);
    chk("R11 irq vblank", {31'b0, irq_o}, 1);
    wr(A_STAT, 0);
    rd(A_STAT, d); chk("R10 write zero keeps", d, 32'h3000);
    wr(A_STAT, 1 << 12);
    rd(A_STAT, d); chk("R10 clear vblank flag", d, 32'h2000);
    chk("R11 irq after clear", {31'b0, irq_o}, 0);
    wr(A_IEN, 1 << 13);
    chk("R11 irq active", {31'b0, irq_o}, 1);
    wr(A_STAT, 1 << 13);
    rd(A_STAT, d); chk("R10 clear active flag", d, 0);
    chk("R11 irq low", {31'b0, irq_o}, 0);

    // R10: flags set again once running
    load_cfg(3);
    run_px(30);
    rd(A_STAT, d); chk("R10 flags re-set", d, 32'h3000);
    chk("R11 irq from active flag", {31'b0, irq_o}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule